// File: doc/BRIEF.md
# Transfer Record Update Unit

This block takes one 8-byte transfer record and returns the record that must be written back after one block of data has moved. The record has six fields: a control byte, a block size, a transfer count, a reload count, a 16-bit source address and a 16-bit destination address. Along with the updated record, the block returns two flags. One asks for an interrupt. The other asks for activation to be switched off. The block reads or writes no memory and does not chain records; it only does the arithmetic and the end-of-run decisions.

Records enter on a valid/ready stream and leave on a second valid/ready stream through one register stage. A record is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high from the next cycle. If `out_ready` is low, the result and both flags stay unchanged. `in_ready` stays low while a result waits, so nothing is lost or overwritten.

Control byte layout:
- bit0: 16-bit unit
- bit1: repeat mode
- bit2: the repeat area is the destination (clear means the source)
- bit3: increment the source
- bit4: increment the destination
- bit5: chain enable (passed through unchanged)
- bit6: repeat interrupt enable
- bit7: unused (passed through unchanged)

Top module: `dtu_update`

## Requirements
- R1: The block length in bytes is the block size field, with 00h meaning 256, doubled when control bit0 is 1. An incrementing address advances by this length.
- R2: An address whose increment bit (bit3 for the source, bit4 for the destination) is 0, and which is not the repeat area, is returned unchanged.
- R3: The count leaves decremented by one, except on the final transfer in repeat mode. A count of 00h becomes FFh, so 00h stands for 256 transfers.
- R4: In normal mode (bit1 = 0), an input count of 01h gives an output count of 00h with both flags set. Any other count gives both flags clear.
- R5: In repeat mode, the repeat-area address (the destination when bit2 = 1, the source when bit2 = 0) increments whatever its increment bit says. The other address follows its own increment bit.
- R6: In repeat mode with an input count of 01h, the repeat-area address keeps its high byte and gets a low byte of 00h, and the output count equals the reload field.
- R7: In repeat mode, both flags equal control bit6 when the input count is 01h, and are clear otherwise.
- R8: The control byte, block size and reload fields are returned unchanged.
- R9: Address arithmetic wraps modulo 2^16.
- R10: `in_ready` is high whenever no result is held or `out_ready` is high. An accepted record's result shows on the outputs with `out_valid` in the next cycle. A result held while `out_ready` is low keeps all its output values stable.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block can accept a record |
| in_ctl | input | 8 | Control byte |
| in_blk | input | 8 | Block size in units, 00h = 256 |
| in_cnt | input | 8 | Remaining transfer count |
| in_rld | input | 8 | Reload count for repeat mode |
| in_src | input | 16 | Source address |
| in_dst | input | 16 | Destination address |
| out_valid | output | 1 | Updated record present |
| out_ready | input | 1 | Consumer takes the updated record |
| out_ctl | output | 8 | Control byte, unchanged |
| out_blk | output | 8 | Block size, unchanged |
| out_cnt | output | 8 | Updated count |
| out_rld | output | 8 | Reload count, unchanged |
| out_src | output | 16 | Updated source address |
| out_dst | output | 16 | Updated destination address |
| out_irq | output | 1 | Interrupt request flag |
| out_disable | output | 1 | Activation-disable flag |

## Verification
Several behaviours are checked by assertions on every cycle:
- the stream rules: ready while empty, and results held stable under back-pressure;
- pass-through of the unchanged fields;
- the one-step count decrement;
- flags staying clear away from the final transfer;
- flags only ever appearing with a zero count (normal mode) or a reloaded count (repeat mode).

Other behaviours only show in the bench's scenarios, which compare against an independent model:
- the exact block length for 00h sizes and 16-bit units;
- the wrap of addresses past FFFFh;
- the low-byte restore of the repeat area;
- a repeat area that increments while its own increment bit is clear.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  parameter int ADDR_W = 16;
  parameter int BYTE_W = 8;
  localparam int LEN_W = BYTE_W + 2;

  localparam int CB_UNIT16 = 0;
  localparam int CB_RPT    = 1;
  localparam int CB_RPTDST = 2;
  localparam int CB_SRCINC = 3;
  localparam int CB_DSTINC = 4;
  localparam int CB_CHAIN  = 5;
  localparam int CB_RPTIE  = 6;

  typedef struct packed {
    logic [BYTE_W-1:0] ctl;
    logic [BYTE_W-1:0] blk;
    logic [BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0] rld;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } dtu_rec_t;
endpackage

// File: rtl/dtu_len_calc.sv
module dtu_len_calc
  import dtu_pkg::*;
(
  input  logic              unit16,
  input  logic [BYTE_W-1:0] blk,
  output logic [LEN_W-1:0]  len_bytes
);
  logic [BYTE_W:0] units;

  always_comb begin
    // a zero size field stands for the full 2^BYTE_W units
    units = {(blk == '0), blk};
    if (unit16) len_bytes = {units, 1'b0};
    else        len_bytes = {1'b0, units};
  end
endmodule

// File: rtl/dtu_addr_step.sv
module dtu_addr_step
  import dtu_pkg::*;
(
  input  logic [ADDR_W-1:0] cur,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic              inc,
  input  logic              restore,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] len_ext;

  always_comb begin
    len_ext = ADDR_W'(len_bytes);
    if (restore)  nxt = {cur[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    else if (inc) nxt = cur + len_ext;
    else          nxt = cur;
  end
endmodule

// File: rtl/dtu_count_ctl.sv
module dtu_count_ctl
  import dtu_pkg::*;
(
  input  logic [BYTE_W-1:0] cnt,
  input  logic [BYTE_W-1:0] rld,
  input  logic              rpt,
  input  logic              rpt_ie,
  output logic              last,
  output logic [BYTE_W-1:0] cnt_nxt,
  output logic              raise
);
  always_comb begin
    last = (cnt == BYTE_W'(1));
    if (rpt && last) cnt_nxt = rld;
    else             cnt_nxt = cnt - BYTE_W'(1);
    raise = last && (!rpt || rpt_ie);
  end
endmodule

// File: rtl/dtu_update.sv
module dtu_update
  import dtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_ctl,
  input  logic [BYTE_W-1:0] in_blk,
  input  logic [BYTE_W-1:0] in_cnt,
  input  logic [BYTE_W-1:0] in_rld,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_ctl,
  output logic [BYTE_W-1:0] out_blk,
  output logic [BYTE_W-1:0] out_cnt,
  output logic [BYTE_W-1:0] out_rld,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic              out_irq,
  output logic              out_disable
);
  localparam int NADDR = 2;

  logic [LEN_W-1:0]  len_bytes;
  logic              last, raise;
  logic [BYTE_W-1:0] cnt_nxt;
  logic              rpt;
  logic [ADDR_W-1:0] cur_a [NADDR];
  logic [ADDR_W-1:0] nxt_a [NADDR];
  logic              inc_bit [NADDR];
  logic              area [NADDR];
  logic              in_fire;
  dtu_rec_t          rec_q;
  logic              flag_q, vld_q;

  assign rpt        = in_ctl[CB_RPT];
  assign cur_a[0]   = in_src;
  assign cur_a[1]   = in_dst;
  assign inc_bit[0] = in_ctl[CB_SRCINC];
  assign inc_bit[1] = in_ctl[CB_DSTINC];
  assign area[0]    = rpt && !in_ctl[CB_RPTDST];
  assign area[1]    = rpt &&  in_ctl[CB_RPTDST];

  dtu_len_calc u_len (
    .unit16    (in_ctl[CB_UNIT16]),
    .blk       (in_blk),
    .len_bytes (len_bytes)
  );

  dtu_count_ctl u_cnt (
    .cnt     (in_cnt),
    .rld     (in_rld),
    .rpt     (rpt),
    .rpt_ie  (in_ctl[CB_RPTIE]),
    .last    (last),
    .cnt_nxt (cnt_nxt),
    .raise   (raise)
  );

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dtu_addr_step u_step (
      .cur       (cur_a[g]),
      .len_bytes (len_bytes),
      .inc       (inc_bit[g] || area[g]),
      .restore   (area[g] && last),
      .nxt       (nxt_a[g])
    );
  end

  assign in_ready = !vld_q || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      flag_q <= 1'b0;
      rec_q  <= '0;
    end else if (in_fire) begin
      vld_q     <= 1'b1;
      flag_q    <= raise;
      rec_q.ctl <= in_ctl;
      rec_q.blk <= in_blk;
      rec_q.rld <= in_rld;
      rec_q.cnt <= cnt_nxt;
      rec_q.src <= nxt_a[0];
      rec_q.dst <= nxt_a[1];
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid   = vld_q;
  assign out_ctl     = rec_q.ctl;
  assign out_blk     = rec_q.blk;
  assign out_cnt     = rec_q.cnt;
  assign out_rld     = rec_q.rld;
  assign out_src     = rec_q.src;
  assign out_dst     = rec_q.dst;
  assign out_irq     = flag_q;
  assign out_disable = flag_q;

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cnt) && $stable(out_src)
      && $stable(out_dst) && $stable(out_ctl) && $stable(out_irq));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_ctl == $past(in_ctl) && out_blk == $past(in_blk)
      && out_rld == $past(in_rld));

  assert_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !(in_ctl[CB_RPT] && in_cnt == 8'h01)
      |=> out_cnt == $past(in_cnt) - 8'h01);

  assert_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cnt != 8'h01 |=> !out_irq && !out_disable);

  assert_flagcnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_irq |-> (out_ctl[CB_RPT] ? (out_cnt == out_rld) : (out_cnt == 8'h00)));

  assert_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !in_ctl[CB_RPT] && !in_ctl[CB_SRCINC] |=> out_src == $past(in_src));
endmodule

// File: tb/dtu_update_tb.sv
module dtu_update_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_ctl = '0, in_blk = '0, in_cnt = '0, in_rld = '0;
  logic [15:0] in_src = '0, in_dst = '0;
  logic in_ready, out_valid, out_irq, out_disable;
  logic [7:0] out_ctl, out_blk, out_cnt, out_rld;
  logic [15:0] out_src, out_dst;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  dtu_update u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctl(in_ctl), .in_blk(in_blk), .in_cnt(in_cnt), .in_rld(in_rld),
    .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_ctl(out_ctl), .out_blk(out_blk), .out_cnt(out_cnt), .out_rld(out_rld),
    .out_src(out_src), .out_dst(out_dst), .out_irq(out_irq), .out_disable(out_disable));

  // expected {ctl,blk,cnt,rld,src,dst,irq,dis} from the requirements
  function automatic logic [65:0] model(input logic [7:0] c, b, n, r,
                                        input logic [15:0] s, d);
    logic [15:0] len, ns, nd;
    logic [7:0] nn;
    logic lastc, f, rp, sarea, darea;
    len = (b == 8'h00) ? 16'd256 : {8'h00, b};
    if (c[0]) len = len * 2;
    rp = c[1];
    sarea = rp && !c[2];
    darea = rp && c[2];
    lastc = (n == 8'h01);
    ns = (c[3] || sarea) ? s + len : s;
    nd = (c[4] || darea) ? d + len : d;
    if (sarea && lastc) ns = {s[15:8], 8'h00};
    if (darea && lastc) nd = {d[15:8], 8'h00};
    nn = (rp && lastc) ? r : n - 8'h01;
    f = lastc && (!rp || c[6]);
    return {c, b, nn, r, ns, nd, f, f};
  endfunction

  function automatic logic [65:0] actual();
    return {out_ctl, out_blk, out_cnt, out_rld, out_src, out_dst, out_irq, out_disable};
  endfunction

  task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [7:0] c, b, n, r,
                     input logic [15:0] s, d);
    @(negedge clk);
    in_ctl = c; in_blk = b; in_cnt = n; in_rld = r; in_src = s; in_dst = d;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {65'b0, out_valid}, 66'd1);
    check(tag, actual(), model(c, b, n, r, s, d));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [65:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", {65'b0, out_valid}, 66'd0);
    check("R11 reset in_ready", {65'b0, in_ready}, 66'd1);
    rst_n = 1'b1;

    run("R1 R2 normal dst inc 1B", 8'h10, 8'h01, 8'h03, 8'h00, 16'h1200, 16'h3400);
    run("R4 normal last", 8'h18, 8'h04, 8'h01, 8'h00, 16'h1200, 16'h3400);
    run("R3 count 00h is 256", 8'h08, 8'h02, 8'h00, 8'h00, 16'h0100, 16'h0200);
    run("R1 size 00h 16bit", 8'h19, 8'h00, 8'h05, 8'h00, 16'h1000, 16'h2000);
    run("R9 wrap", 8'h19, 8'h10, 8'h07, 8'h00, 16'hFFF0, 16'hFFFF);
    run("R5 repeat dst area inc bit clear", 8'h06, 8'h01, 8'h03, 8'h03, 16'h5000, 16'h7702);
    run("R6 R7 repeat last ie=0", 8'h06, 8'h01, 8'h01, 8'h03, 16'h5000, 16'h7702);
    run("R6 R7 repeat last ie=1", 8'h4E, 8'h01, 8'h01, 8'h03, 16'h5003, 16'h7702);
    run("R6 repeat src area last", 8'h52, 8'h02, 8'h01, 8'h09, 16'h6512, 16'h8000);
    run("R8 passthrough chain bit", 8'hA0, 8'h33, 8'h09, 8'h5A, 16'h0001, 16'h0002);

    // R10 back-pressure: result held, input refused
    @(negedge clk);
    out_ready = 1'b0;
    in_ctl = 8'h18; in_blk = 8'h08; in_cnt = 8'h02; in_rld = 8'h00;
    in_src = 16'h4000; in_dst = 16'h4100; in_valid = 1'b1;
    @(negedge clk);
    held = model(8'h18, 8'h08, 8'h02, 8'h00, 16'h4000, 16'h4100);
    in_cnt = 8'h01; in_src = 16'h9999;
    check("R10 stalled ready low", {65'b0, in_ready}, 66'd0);
    repeat (3) @(negedge clk);
    check("R10 held result", actual(), held);
    check("R10 held valid", {65'b0, out_valid}, 66'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next accepted", actual(), model(8'h18, 8'h08, 8'h01, 8'h00, 16'h9999, 16'h4100));
    @(negedge clk);
    check("R10 drained", {65'b0, out_valid}, 66'd0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] c, b, n, r;
      logic [15:0] s, d;
      c = 8'($urandom); b = 8'($urandom); r = 8'($urandom);
      n = ($urandom % 4 == 0) ? 8'h01 : 8'($urandom);
      s = 16'($urandom); d = 16'($urandom);
      run("R1 R3 R5 R6 R7 R9 random", c, b, n, r, s, d);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule